// File: doc/BRIEF.md
# EDID Segment and Offset Tracker

This block sits in front of an I2C-over-AUX transport. It watches each request descriptor and keeps two 8-bit pointers up to date: the EDID segment and the EDID byte offset. An I2C write to the segment-pointer address loads the segment. An I2C write to the EDID address loads the offset. A qualifying I2C read is an I2C read that has the middle-of-transaction (MOT) flag set and a nonzero size. Each qualifying read moves the offset on by a fixed 16-byte chunk.

Some sinks mishandle the MOT flag. To cover them, the block re-sends the pointers in front of any qualifying read whose offset is in the middle of a 128-byte block. It issues one-byte helper writes through a valid/ready stream. The segment goes first, and only when it is nonzero. The offset follows, sent to the read's own address. The transport sends every helper with no address phase and no stop condition. The upstream request stays pending (`req_ready` low) until the last helper has been accepted. The read is then released, and its handshake is the point at which the pointers are updated. When the advanced offset lands on a block end (0x80, or 0x100 which wraps to 0x00), the segment is cleared.

Top module: `edid_ptr_tracker`

## Requirements
- R1: After reset the segment and offset are 0x00, `hlp_valid` is low, and `req_ready` is high.
- R2: An accepted I2C write (`req_native`=0, `req_read`=0) with nonzero size to address 0x30 loads `req_data` into the segment. A size of 0 leaves both registers unchanged.
- R3: An accepted I2C write with nonzero size to address 0x50 loads `req_data` into the offset.
- R4: Native requests, writes to any other address and non-qualifying reads leave the segment and offset unchanged. Non-qualifying reads are reads with MOT=0, with size 0, or native.
- R5: A qualifying read (I2C, `req_read`=1, `req_mot`=1, size≠0) adds 16 to the offset modulo 256 when it is accepted, whether or not helpers were sent.
- R6: A qualifying read whose offset is a multiple of 128 (offset bits [6:0] all zero) produces no helper and is accepted in the cycle it is presented. Every non-qualifying request is also accepted in the cycle it is presented.
- R7: A qualifying read with an unaligned offset and a nonzero segment first emits a helper with `hlp_addr`=0x30 and `hlp_data`=segment. With a zero segment this helper is skipped.
- R8: A qualifying read with an unaligned offset emits a helper with `hlp_addr`=`req_addr` and `hlp_data`=offset. This helper is always the last one.
- R9: Helpers are emitted one at a time and hold their data while `hlp_ready` is low. `req_ready` stays low from the moment helpers are due until the last helper is accepted, and `req_ready` and `hlp_valid` are never high together.
- R10: If the offset after a qualifying read's advance equals 0x80 or 0x00, the segment becomes 0x00 in the same update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor present; held with its fields until accepted |
| req_ready | output | 1 | Request accepted (released to the transport) this cycle |
| req_native | input | 1 | 1 = native AUX request, 0 = I2C-over-AUX |
| req_read | input | 1 | 1 = read, 0 = write |
| req_mot | input | 1 | Middle-of-transaction flag |
| req_addr | input | 7 | I2C target address |
| req_data | input | 8 | First data byte of a write |
| req_size | input | 8 | Transfer size in bytes |
| hlp_valid | output | 1 | Helper one-byte write available |
| hlp_ready | input | 1 | Transport accepts the helper |
| hlp_addr | output | 7 | Helper target address |
| hlp_data | output | 8 | Helper data byte |
| seg_q | output | 8 | Current EDID segment |
| ofs_q | output | 8 | Current EDID byte offset |

## Verification
The hardest case to reach is the one where both helpers are sent and one of them is stalled: a nonzero segment combined with an unaligned offset, and back-pressure on the helper stream. Reaching it takes earlier writes that set the pointers. The bench sweeps segment values against every 16-byte offset step plus odd offsets. It sets each pair through the port with pointer writes, then issues a qualifying read under several `hlp_ready` stall patterns. The segment clear happens only at 0x80 and at the wrap to 0x00. A run of consecutive reads steps the offset through the whole 256-byte range to reach both points.

// File: rtl/edid_trk_pkg.sv
package edid_trk_pkg;
   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_SEG  = 2'd1,
      HS_OFS  = 2'd2,
      HS_REL  = 2'd3
   } hlp_state_e;
endpackage

// File: rtl/edid_trk_decode.sv
module edid_trk_decode #(
   parameter int ADDR_W = 7,
   parameter int SIZE_W = 8,
   parameter logic [ADDR_W-1:0] SEG_ADDR = 7'h30,
   parameter logic [ADDR_W-1:0] OFS_ADDR = 7'h50
) (
   input  logic              native_i,
   input  logic              read_i,
   input  logic              mot_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SIZE_W-1:0] size_i,
   output logic              qual_rd_o,
   output logic              seg_wr_o,
   output logic              ofs_wr_o
);
   logic has_len;
   logic i2c_wr;

   always_comb begin
      has_len   = (size_i != '0);
      i2c_wr    = !native_i && !read_i && has_len;
      qual_rd_o = !native_i && read_i && mot_i && has_len;
      seg_wr_o  = i2c_wr && (addr_i == SEG_ADDR);
      ofs_wr_o  = i2c_wr && (addr_i == OFS_ADDR);
   end
endmodule

// File: rtl/edid_trk_regs.sv
module edid_trk_regs #(
   parameter int DATA_W    = 8,
   parameter int BLOCK_LEN = 128,
   parameter int CHUNK_LEN = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_ld_i,
   input  logic              ofs_ld_i,
   input  logic              adv_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic [DATA_W-1:0] seg_o,
   output logic [DATA_W-1:0] ofs_o
);
   localparam int WRAP = 1 << DATA_W;
   localparam logic [DATA_W-1:0] STEP  = DATA_W'(CHUNK_LEN % WRAP);
   localparam logic [DATA_W-1:0] END_A = DATA_W'(BLOCK_LEN % WRAP);
   localparam logic [DATA_W-1:0] END_B = DATA_W'((2 * BLOCK_LEN) % WRAP);

   logic [DATA_W-1:0] ofs_nxt;
   logic              at_end;

   always_comb begin
      ofs_nxt = ofs_o + STEP;
      at_end  = (ofs_nxt == END_A) || (ofs_nxt == END_B);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_o <= '0;
         ofs_o <= '0;
      end else begin
         if (seg_ld_i) seg_o <= byte_i;
         if (ofs_ld_i) ofs_o <= byte_i;
         if (adv_i) begin
            ofs_o <= ofs_nxt;
            if (at_end) seg_o <= '0;
         end
      end
   end

   // R5
   adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |=> (ofs_o == DATA_W'($past(ofs_o) + STEP)));
   // R10
   seg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && (DATA_W'(ofs_o + STEP) == END_A)) |=> (seg_o == '0));
   // R4
   no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(seg_ld_i || ofs_ld_i || adv_i) |=> ($stable(seg_o) && $stable(ofs_o)));
endmodule

// File: rtl/edid_trk_seq.sv
module edid_trk_seq
   import edid_trk_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int BLOCK_LEN = 128,
   parameter logic [ADDR_W-1:0] SEG_ADDR = 7'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              qual_rd_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] seg_i,
   input  logic [DATA_W-1:0] ofs_i,
   output logic              req_ready_o,
   output logic              hlp_valid_o,
   input  logic              hlp_ready_i,
   output logic [ADDR_W-1:0] hlp_addr_o,
   output logic [DATA_W-1:0] hlp_data_o
);
   localparam int WRAP = 1 << DATA_W;

   hlp_state_e st_q, st_d;
   logic       unaligned;
   logic       needs_hlp;

   generate
      if ((BLOCK_LEN & (BLOCK_LEN - 1)) == 0) begin : g_mask_align
         localparam logic [DATA_W-1:0] MASK = DATA_W'((BLOCK_LEN - 1) % WRAP);
         assign unaligned = (ofs_i & MASK) != '0;
      end else begin : g_mod_align
         assign unaligned = (int'(ofs_i) % BLOCK_LEN) != 0;
      end
   endgenerate

   assign needs_hlp = req_valid_i && qual_rd_i && unaligned;

   always_comb begin
      st_d        = st_q;
      req_ready_o = 1'b0;
      hlp_valid_o = 1'b0;
      hlp_addr_o  = SEG_ADDR;
      hlp_data_o  = seg_i;
      unique case (st_q)
         HS_IDLE: begin
            req_ready_o = !needs_hlp;
            if (needs_hlp) st_d = (seg_i != '0) ? HS_SEG : HS_OFS;
         end
         HS_SEG: begin
            hlp_valid_o = 1'b1;
            if (hlp_ready_i) st_d = HS_OFS;
         end
         HS_OFS: begin
            hlp_valid_o = 1'b1;
            hlp_addr_o  = req_addr_i;
            hlp_data_o  = ofs_i;
            if (hlp_ready_i) st_d = HS_REL;
         end
         HS_REL: begin
            req_ready_o = 1'b1;
            if (req_valid_i) st_d = HS_IDLE;
         end
         default: st_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= HS_IDLE;
      else        st_q <= st_d;
   end

   // R9
   hlp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hlp_valid_o && !hlp_ready_i) |=> (hlp_valid_o && $stable(hlp_data_o)));
   // R9
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hlp_valid_o && req_ready_o));
   // R7
   seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_SEG) |-> (seg_i != '0));
   // R6
   aligned_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_IDLE && req_valid_i && !unaligned) |-> req_ready_o);
endmodule

// File: rtl/edid_ptr_tracker.sv
module edid_ptr_tracker #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int SIZE_W    = 8,
   parameter int BLOCK_LEN = 128,
   parameter int CHUNK_LEN = 16,
   parameter logic [ADDR_W-1:0] SEG_ADDR = 7'h30,
   parameter logic [ADDR_W-1:0] OFS_ADDR = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_native,
   input  logic              req_read,
   input  logic              req_mot,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   input  logic [SIZE_W-1:0] req_size,
   output logic              hlp_valid,
   input  logic              hlp_ready,
   output logic [ADDR_W-1:0] hlp_addr,
   output logic [DATA_W-1:0] hlp_data,
   output logic [DATA_W-1:0] seg_q,
   output logic [DATA_W-1:0] ofs_q
);
   generate
      if (BLOCK_LEN < 1 || BLOCK_LEN > (1 << DATA_W)) begin : g_bad_block
         $error("BLOCK_LEN out of range");
      end
      if (CHUNK_LEN < 1 || CHUNK_LEN > BLOCK_LEN) begin : g_bad_chunk
         $error("CHUNK_LEN out of range");
      end
      if (ADDR_W < 1 || DATA_W < 2 || SIZE_W < 1) begin : g_bad_width
         $error("width parameter out of range");
      end
   endgenerate

   logic qual_rd, seg_wr, ofs_wr, accept;

   edid_trk_decode #(
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
      .SEG_ADDR(SEG_ADDR), .OFS_ADDR(OFS_ADDR)
   ) decode_i (
      .native_i(req_native), .read_i(req_read), .mot_i(req_mot),
      .addr_i(req_addr), .size_i(req_size),
      .qual_rd_o(qual_rd), .seg_wr_o(seg_wr), .ofs_wr_o(ofs_wr)
   );

   assign accept = req_valid && req_ready;

   edid_trk_regs #(
      .DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN), .CHUNK_LEN(CHUNK_LEN)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .seg_ld_i(accept && seg_wr), .ofs_ld_i(accept && ofs_wr),
      .adv_i(accept && qual_rd), .byte_i(req_data),
      .seg_o(seg_q), .ofs_o(ofs_q)
   );

   edid_trk_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN), .SEG_ADDR(SEG_ADDR)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .qual_rd_i(qual_rd), .req_addr_i(req_addr),
      .seg_i(seg_q), .ofs_i(ofs_q),
      .req_ready_o(req_ready),
      .hlp_valid_o(hlp_valid), .hlp_ready_i(hlp_ready),
      .hlp_addr_o(hlp_addr), .hlp_data_o(hlp_data)
   );

   // R2
   seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && seg_wr) |=> (seg_q == $past(req_data)));
   // R3
   ofs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ofs_wr) |=> (ofs_q == $past(req_data)));
endmodule

// File: tb/edid_ptr_tracker_tb.sv
module edid_ptr_tracker_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_native = 1'b0, req_read = 1'b0, req_mot = 1'b0;
   logic [6:0] req_addr = '0;
   logic [7:0] req_data = '0, req_size = '0;
   logic       hlp_ready = 1'b0;
   logic       req_ready, hlp_valid;
   logic [6:0] hlp_addr;
   logic [7:0] hlp_data, seg_q, ofs_q;

   int total = 0;
   int fails = 0;
   logic [7:0] mseg = '0, mofs = '0;

   always #(CLK_P/2) clk = ~clk;

   edid_ptr_tracker dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_native(req_native), .req_read(req_read), .req_mot(req_mot),
      .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
      .hlp_valid(hlp_valid), .hlp_ready(hlp_ready),
      .hlp_addr(hlp_addr), .hlp_data(hlp_data),
      .seg_q(seg_q), .ofs_q(ofs_q)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", total, fails);
   endtask

   // One request with a helper stall pattern; model checks helpers and registers.
   task automatic do_req(input bit nat, input bit rd, input bit mot,
                         input logic [6:0] a, input logic [7:0] d,
                         input logic [7:0] sz, input int stall);
      logic [6:0] ha[4];
      logic [7:0] hd[4];
      logic [6:0] ea[2];
      logic [7:0] ed[2];
      int hn = 0, en = 0, cyc = 0, stc = 0;
      bit done = 0, qual;
      qual = !nat && rd && mot && (sz != 0);
      if (qual && (mofs[6:0] != 0)) begin
         if (mseg != 0) begin ea[en] = 7'h30; ed[en] = mseg; en++; end
         ea[en] = a; ed[en] = mofs; en++;
      end
      @(negedge clk);
      req_native = nat; req_read = rd; req_mot = mot;
      req_addr = a; req_data = d; req_size = sz; req_valid = 1'b1;
      while (!done && cyc < 60) begin
         hlp_ready = (stall == 0) || ((stc % (stall + 1)) == stall);
         #1;
         if (hlp_valid && req_ready) chk(0, "R9 ready and helper together", 1, 0);
         if (hlp_valid && hlp_ready && hn < 4) begin
            ha[hn] = hlp_addr; hd[hn] = hlp_data; hn++;
         end
         if (req_ready) done = 1;
         else begin stc++; cyc++; @(negedge clk); end
      end
      @(negedge clk);
      req_valid = 1'b0; hlp_ready = 1'b0;
      chk(hn == en, "R9 helper count", hn, en);
      if (en == 0) chk(cyc == 0, "R6 accepted without wait", cyc, 0);
      for (int i = 0; i < en && i < hn; i++) begin
         if (i == 0 && en == 2) begin
            chk(ha[i] == ea[i], "R7 segment helper addr", ha[i], ea[i]);
            chk(hd[i] == ed[i], "R7 segment helper data", hd[i], ed[i]);
         end else begin
            chk(ha[i] == ea[i], "R8 offset helper addr", ha[i], ea[i]);
            chk(hd[i] == ed[i], "R8 offset helper data", hd[i], ed[i]);
         end
      end
      if (!nat && !rd && sz != 0) begin
         if (a == 7'h30) mseg = d;
         if (a == 7'h50) mofs = d;
      end
      if (qual) begin
         mofs = mofs + 8'd16;
         if (mofs == 8'h80 || mofs == 8'h00) mseg = 8'h00;
      end
      chk(ofs_q == mofs, qual ? "R5 offset after request" : "R3/R4 offset after request", ofs_q, mofs);
      chk(seg_q == mseg, qual ? "R10 segment after request" : "R2/R4 segment after request", seg_q, mseg);
   endtask

   initial begin
      #(CLK_P * 150000);
      chk(0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int segs[4] = '{0, 1, 2, 8'h7F};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(seg_q == 0, "R1 segment reset", seg_q, 0);
      chk(ofs_q == 0, "R1 offset reset", ofs_q, 0);
      chk(hlp_valid == 0, "R1 no helper", hlp_valid, 0);
      chk(req_ready == 1, "R1 ready", req_ready, 1);

      // R2 R3 pointer writes, R4 ignored requests
      do_req(0, 0, 0, 7'h30, 8'h05, 1, 0);   // r2_ load segment
      do_req(0, 0, 0, 7'h30, 8'h09, 0, 0);   // r2_ size zero ignored
      do_req(0, 0, 1, 7'h50, 8'h33, 2, 0);   // r3_ load offset
      do_req(1, 0, 0, 7'h30, 8'hAA, 1, 0);   // r4_ native write
      do_req(1, 0, 0, 7'h50, 8'hAA, 1, 0);   // r4_ native write
      do_req(0, 0, 0, 7'h51, 8'hAA, 1, 0);   // r4_ other address
      do_req(0, 1, 0, 7'h50, 8'h00, 16, 0);  // r4_ read without MOT
      do_req(0, 1, 1, 7'h50, 8'h00, 0, 0);   // r4_ read of size zero
      do_req(1, 1, 1, 7'h50, 8'h00, 16, 0);  // r4_ native read

      // Sweep: segment x offset x stall pattern, qualifying reads (R5..R10)
      foreach (segs[s]) begin
         for (int o = 0; o < 18; o++) begin
            logic [7:0] ov;
            ov = (o < 16) ? 8'(o * 16) : ((o == 16) ? 8'h05 : 8'hFF);
            do_req(0, 0, 0, 7'h30, 8'(segs[s]), 1, 0);
            do_req(0, 0, 0, 7'h50, ov, 1, 0);
            do_req(0, 1, 1, 7'h50, 8'h00, 16, (o + s) % 3);
         end
      end

      // Full walk through 256 bytes with segment reloads: R10 at 0x80 and wrap to 0x00
      do_req(0, 0, 0, 7'h50, 8'h00, 1, 0);
      for (int k = 0; k < 16; k++) begin
         if (k == 3 || k == 11) do_req(0, 0, 0, 7'h30, 8'h01, 1, 0);
         do_req(0, 1, 1, 7'h50, 8'h00, 16, k % 2);
      end

      summary();
      $finish;
   end
endmodule